// File: doc/BRIEF.md
# PIO Timing Clock-Count Encoder

This block turns the standard ATA PIO timing figures (address setup, strobe active time and full cycle time, in nanoseconds) into counts of the host bus clock for a pair of drives sharing one cable. It then packs the counts into the byte layout a downstream timing generator expects. Software or a control sequencer supplies the bus frequency in MHz and a mode code per drive, then pulses `start_i`. The block works through the six conversions one at a time on a single shared divider. When all three bytes are ready it updates them together and raises `valid_o` for one cycle.

Every conversion rounds up to whole clocks. Each count is then clamped to the range its field can hold. The two drives get separate strobe and recovery counts, but they share one address-setup field, which takes the slower of the two drives. A drive marked absent takes the smallest legal values, so it never stretches the shared field.

Top module: `pio_enc_top`

## Requirements
- R1: Every clock count is ceil(ns × bus_mhz / 1000), computed as (ns × bus_mhz + 999) / 1000 in integer arithmetic. A product that is an exact multiple of 1000 is not rounded further. The figures used are: mode 0 setup 70, active 165, cycle 600; mode 1 setup 50, active 125, cycle 383; mode 2 setup 30, active 100, cycle 240; mode 3 setup 30, active 80, cycle 180.
- R2: The recovery time is formed in nanoseconds as cycle − setup − active, and only then converted to clocks.
- R3: Counts are clamped after rounding: address setup to 1..4, active to 1..16 and recovery to 2..17. This holds for bus_mhz = 0 as well.
- R4: Mode code 7 means no drive is present. That drive uses address 1, active 1 and recovery 2, so its cycle byte is 0x00.
- R5: The shared address-setup field carries the larger of the two drives' address counts.
- R6: Mode codes 4, 5 and 6 are treated as mode 3.
- R7: Each cycle byte holds (active − 1) in bits 7:4 and (recovery − 2) in bits 3:0. The shared byte holds the read-prefetch flag (parameter PREFETCH, default 1) in bit 6 and (address − 1) in bits 5:4. Bits 3:1 hold (ready − 2) with ready fixed at 2, so they are 0. Bits 7 and 0 are 0.
- R8: After reset all three bytes are 0x00 and `valid_o` and `busy_o` are low. `valid_o` is a one-cycle pulse in the cycle the new bytes first appear. The bytes hold their values in every other cycle.
- R9: A `start_i` seen while `busy_o` is low latches the frequency and both modes, and `busy_o` is high in the next cycle. While `busy_o` is high, `start_i` and input changes are ignored: they produce no extra result and do not alter the one in progress.
- R10: `busy_o` is already low in the cycle `valid_o` is high. A `start_i` in that same cycle is accepted and yields the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a conversion when idle |
| bus_mhz_i | input | MHZ_W | Bus frequency in MHz |
| mode0_i | input | 3 | Drive 0 mode code (0..6, 7 = absent) |
| mode1_i | input | 3 | Drive 1 mode code (0..6, 7 = absent) |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle pulse: bytes updated |
| cyc0_o | output | 8 | Drive 0 cycle byte |
| cyc1_o | output | 8 | Drive 1 cycle byte |
| misc_o | output | 8 | Shared address/ready/prefetch byte |

## Verification
Two events can fall in the same cycle: the completion pulse of one result and the acceptance of the next start. The bench's driver waits only for `busy_o` to drop before presenting the next request, so back-to-back requests land on the `valid_o` cycle itself. The scoreboard then expects both results in order, each with the right bytes. A second overlap is a start presented while busy with different operands. That run is judged by the same scoreboard, which must see only the first operands' result and no extra pulse.

// File: rtl/pio_enc_pkg.sv
package pio_enc_pkg;
  localparam int NS_W  = 10;
  localparam int CNT_W = 8;
  localparam logic [2:0] MODE_ABSENT = 3'd7;

  // Nanosecond figure for a mode and field (0 setup, 1 active, 2 recovery).
  function automatic logic [NS_W-1:0] pio_ns(input logic [1:0] mode, input logic [1:0] fld);
    logic [NS_W-1:0] s, a, c;
    case (mode)
      2'd0: begin s = 10'd70; a = 10'd165; c = 10'd600; end
      2'd1: begin s = 10'd50; a = 10'd125; c = 10'd383; end
      2'd2: begin s = 10'd30; a = 10'd100; c = 10'd240; end
      default: begin s = 10'd30; a = 10'd80; c = 10'd180; end
    endcase
    case (fld)
      2'd0: pio_ns = s;
      2'd1: pio_ns = a;
      default: pio_ns = c - s - a;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] clampv(input logic [CNT_W-1:0] v,
                                              input logic [CNT_W-1:0] lo,
                                              input logic [CNT_W-1:0] hi);
    if (v < lo) clampv = lo;
    else if (v > hi) clampv = hi;
    else clampv = v;
  endfunction
endpackage

// File: rtl/pio_enc_div.sv
module pio_enc_div #(
  parameter int W       = 19,
  parameter int DIVISOR = 1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int RW  = $clog2(DIVISOR);
  localparam int CW  = $clog2(W + 1);
  localparam logic [RW:0] DIV_C = DIVISOR[RW:0];

  logic [RW-1:0] rem_q;
  logic [W-1:0]  dq_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [RW:0]   trial;
  logic          qbit;
  logic [RW-1:0] rem_n;

  always_comb begin
    trial = {rem_q, dq_q[W-1]};
    qbit  = (trial >= DIV_C);
    rem_n = qbit ? RW'(trial - DIV_C) : trial[RW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dq_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        dq_q  <= dividend;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= rem_n;
        dq_q  <= {dq_q[W-2:0], qbit};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quotient = dq_q;
endmodule

// File: rtl/pio_enc_pack.sv
module pio_enc_pack
  import pio_enc_pkg::*;
#(
  parameter bit PREFETCH = 1'b1,
  parameter int READY    = 2
) (
  input  logic [1:0][2:0][CNT_W-1:0] raw_i,
  input  logic [1:0]                 absent_i,
  output logic [1:0][7:0]            cyc_o,
  output logic [7:0]                 misc_o
);
  logic [1:0][CNT_W-1:0] addr;

  for (genvar d = 0; d < 2; d++) begin : g_drv
    logic [CNT_W-1:0] ad, dt, rc;
    always_comb begin
      if (absent_i[d]) begin
        ad = CNT_W'(1);
        dt = CNT_W'(1);
        rc = CNT_W'(2);
      end else begin
        ad = clampv(raw_i[d][0], CNT_W'(1), CNT_W'(4));
        dt = clampv(raw_i[d][1], CNT_W'(1), CNT_W'(16));
        rc = clampv(raw_i[d][2], CNT_W'(2), CNT_W'(17));
      end
      addr[d]  = ad;
      cyc_o[d] = {4'(dt - CNT_W'(1)), 4'(rc - CNT_W'(2))};
    end
  end

  logic [CNT_W-1:0] ax;
  always_comb begin
    ax     = (addr[0] > addr[1]) ? addr[0] : addr[1];
    misc_o = {1'b0, PREFETCH, 2'(ax - CNT_W'(1)), 3'(READY - 2), 1'b0};
  end
endmodule

// File: rtl/pio_enc_top.sv
module pio_enc_top
  import pio_enc_pkg::*;
#(
  parameter int MHZ_W    = 8,
  parameter bit PREFETCH = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [MHZ_W-1:0] bus_mhz_i,
  input  logic [2:0]       mode0_i,
  input  logic [2:0]       mode1_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [7:0]       cyc0_o,
  output logic [7:0]       cyc1_o,
  output logic [7:0]       misc_o
);
  localparam int DVD_W   = NS_W + MHZ_W + 1;
  localparam int DIVISOR = 1000;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_PACK} state_e;
  state_e state_q;

  logic [MHZ_W-1:0]          lat_mhz;
  logic [1:0][1:0]           lat_mode;
  logic [1:0]                lat_abs;
  logic                      drv_q;
  logic [1:0]                fld_q;
  logic [1:0][2:0][CNT_W-1:0] raw_q;

  logic             div_start, div_done;
  logic [DVD_W-1:0] dividend, quotient;
  logic [NS_W-1:0]  ns_cur;
  logic [CNT_W-1:0] q_sat;
  logic [1:0][7:0]  cyc_n;
  logic [7:0]       misc_n;

  function automatic logic [1:0] lim_mode(input logic [2:0] m);
    return (m > 3'd3) ? 2'd3 : m[1:0];
  endfunction

  always_comb begin
    div_start = (state_q == S_ISSUE);
    ns_cur    = pio_ns(lat_mode[drv_q], fld_q);
    dividend  = DVD_W'(ns_cur) * DVD_W'(lat_mhz) + DVD_W'(DIVISOR - 1);
    q_sat     = (|quotient[DVD_W-1:CNT_W]) ? {CNT_W{1'b1}} : quotient[CNT_W-1:0];
  end

  pio_enc_div #(.W(DVD_W), .DIVISOR(DIVISOR)) div_i (
    .clk(clk), .rst(rst), .start(div_start), .dividend(dividend),
    .done(div_done), .quotient(quotient)
  );

  pio_enc_pack #(.PREFETCH(PREFETCH), .READY(2)) pack_i (
    .raw_i(raw_q), .absent_i(lat_abs), .cyc_o(cyc_n), .misc_o(misc_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      lat_mhz  <= '0;
      lat_mode <= '0;
      lat_abs  <= '0;
      drv_q    <= 1'b0;
      fld_q    <= '0;
      raw_q    <= '0;
      valid_o  <= 1'b0;
      cyc0_o   <= '0;
      cyc1_o   <= '0;
      misc_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          lat_mhz     <= bus_mhz_i;
          lat_mode[0] <= lim_mode(mode0_i);
          lat_mode[1] <= lim_mode(mode1_i);
          lat_abs     <= {mode1_i == MODE_ABSENT, mode0_i == MODE_ABSENT};
          drv_q       <= 1'b0;
          fld_q       <= '0;
          state_q     <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (div_done) begin
          raw_q[drv_q][fld_q] <= q_sat;
          if (fld_q == 2'd2) begin
            fld_q <= '0;
            if (drv_q) state_q <= S_PACK;
            else begin
              drv_q   <= 1'b1;
              state_q <= S_ISSUE;
            end
          end else begin
            fld_q   <= fld_q + 2'd1;
            state_q <= S_ISSUE;
          end
        end
        default: begin
          cyc0_o  <= cyc_n[0];
          cyc1_o  <= cyc_n[1];
          misc_o  <= misc_n;
          valid_o <= 1'b1;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
endmodule

// File: rtl/pio_enc_chk.sv
module pio_enc_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       busy_o,
  input logic       valid_o,
  input logic [7:0] cyc0_o,
  input logic [7:0] cyc1_o,
  input logic [7:0] misc_o,
  input logic [1:0] abs_q
);
  a_r9_accept: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o |=> busy_o);

  a_r10_idle_on_valid: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !busy_o);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !valid_o |=> valid_o || ($stable(cyc0_o) && $stable(cyc1_o) && $stable(misc_o)));

  a_r4_absent0: assert property (@(posedge clk) disable iff (rst)
    valid_o && abs_q[0] |-> cyc0_o == 8'h00);

  a_r4_absent1: assert property (@(posedge clk) disable iff (rst)
    valid_o && abs_q[1] |-> cyc1_o == 8'h00);
endmodule

bind pio_enc_top pio_enc_chk chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .valid_o(valid_o),
  .cyc0_o(cyc0_o), .cyc1_o(cyc1_o), .misc_o(misc_o), .abs_q(lat_abs)
);

// File: tb/pio_enc_top_tb_top.sv
module pio_enc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] bus_mhz_i = '0;
  logic [2:0] mode0_i = '0, mode1_i = '0;
  logic       busy_o, valid_o;
  logic [7:0] cyc0_o, cyc1_o, misc_o;

  int checks = 0, errors = 0, pushes = 0, pulses = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pio_enc_top dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .bus_mhz_i(bus_mhz_i),
    .mode0_i(mode0_i), .mode1_i(mode1_i), .busy_o(busy_o), .valid_o(valid_o),
    .cyc0_o(cyc0_o), .cyc1_o(cyc1_o), .misc_o(misc_o)
  );

  function automatic int to_clk(int ns, int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [23:0] model(int mhz, int m0, int m1);
    int s[4] = '{70, 50, 30, 30};
    int a[4] = '{165, 125, 100, 80};
    int c[4] = '{600, 383, 240, 180};
    int ad[2], dt[2], rc[2];
    int ax;
    logic [7:0] cy[2];
    logic [7:0] mi;
    for (int d = 0; d < 2; d++) begin
      int m = (d == 0) ? m0 : m1;
      if (m == 7) begin
        ad[d] = 1; dt[d] = 1; rc[d] = 2;
      end else begin
        int k = (m > 3) ? 3 : m;
        ad[d] = lim(to_clk(s[k], mhz), 1, 4);
        dt[d] = lim(to_clk(a[k], mhz), 1, 16);
        rc[d] = lim(to_clk(c[k] - s[k] - a[k], mhz), 2, 17);
      end
      cy[d] = 8'(((dt[d] - 1) << 4) | (rc[d] - 2));
    end
    ax = (ad[0] > ad[1]) ? ad[0] : ad[1];
    mi = 8'(8'h40 | ((ax - 1) << 4));
    return {cy[0], cy[1], mi};
  endfunction

  task automatic check(bit ok, string req, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(int mhz, int m0, int m1, string tag);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    bus_mhz_i = 8'(mhz);
    mode0_i   = 3'(m0);
    mode1_i   = 3'(m1);
    start_i   = 1'b1;
    exp_q.push_back(model(mhz, m0, m1));
    tag_q.push_back(tag);
    pushes++;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      pulses++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected result", {cyc0_o, cyc1_o, misc_o}, 24'h0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({cyc0_o, cyc1_o, misc_o} == e, t, "result bytes", {cyc0_o, cyc1_o, misc_o}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 24'h0, 24'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({cyc0_o, cyc1_o, misc_o} == 24'h0, "R8", "reset bytes", {cyc0_o, cyc1_o, misc_o}, 24'h0);
    check(!busy_o && !valid_o, "R8", "reset flags", {22'h0, busy_o, valid_o}, 24'h0);

    send(33, 0, 0, "R1");
    send(100, 3, 3, "R1");    // 30 ns * 100 MHz = exact 3 clocks
    send(33, 3, 1, "R5");     // back-to-back: start lands on the valid cycle (R10)
    send(100, 2, 3, "R2");
    send(50, 2, 7, "R4");
    send(20, 7, 7, "R4");
    send(255, 0, 3, "R3");
    send(1, 1, 2, "R3");
    send(0, 3, 0, "R3");
    send(66, 5, 6, "R6");
    send(40, 4, 2, "R6");
    send(80, 1, 0, "R7");

    // R9: starts and input changes while busy are ignored
    send(45, 1, 2, "R9");
    repeat (3) begin
      @(negedge clk);
      bus_mhz_i = 8'd200; mode0_i = 3'd0; mode1_i = 3'd7; start_i = 1'b1;
    end
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (300) @(negedge clk);
    check(!busy_o, "R9", "no restart from busy start", {23'h0, busy_o}, 24'h0);

    // R8: outputs hold while idle
    held = {cyc0_o, cyc1_o, misc_o};
    repeat (20) @(negedge clk);
    check({cyc0_o, cyc1_o, misc_o} == held, "R8", "bytes hold", {cyc0_o, cyc1_o, misc_o}, held);

    check(exp_q.size() == 0, "R8", "pending results", 24'(exp_q.size()), 24'h0);
    check(pulses == pushes, "R9", "pulse count", 24'(pulses), 24'(pushes));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule